// File: doc/BRIEF.md
# Byte-Wide Table CRC-32 Engine

This block folds a byte stream into a reflected 32-bit cyclic redundancy check at a rate of one byte per clock. Each accepted byte updates the running remainder with one eight-bit right shift and one XOR against a word fetched from a 256-word lookup memory. The lookup memory is never loaded from outside. After reset a small sequencer fills it: for each of the 256 indices it performs eight single-bit division steps, one per clock, and writes the finished word.

A host waits for `ready_o`, then marks the first byte of a message with `start_i` (on the same cycle as the byte, or on an earlier cycle with no byte). It presents bytes on `data_i` with `valid_i`, and reads the finished checksum on `crc_o` once the last byte has been taken. The output always shows the complemented running remainder. No per-message handshake is needed beyond the preset.

Top module: `crc32_table_engine`

## Requirements
- R1: While reset is high and during the table build, `ready_o` is 0 and `crc_o` reads 0x00000000, the complement of the all-ones preset.
- R2: `ready_o` rises exactly after the 2048th rising clock edge at which reset is low (256 indices times 8 steps), and no earlier.
- R3: Once high, `ready_o` stays high until the next reset.
- R4: While `ready_o` is 0, `start_i`, `valid_i` and `data_i` have no effect: `crc_o` keeps its value, and the running remainder after the build is still the all-ones preset.
- R5: A byte is accepted on every edge where `ready_o` and `valid_i` are high. From the next cycle on, `crc_o` is the complement of the remainder updated by that byte. The update XORs the byte into bits 7:0, then performs eight right shifts, and each shift XORs the register with 0xEDB88320 when the bit that leaves bit 0 was 1.
- R6: Bytes can be accepted on consecutive cycles with no stall. The nine bytes 0x31 through 0x39, sent after a preset, give `crc_o` = 0xCBF43926.
- R7: `start_i` with `valid_i` low (and `ready_o` high) presets the remainder to all ones, so that `crc_o` reads 0x00000000 on the next cycle.
- R8: A byte accepted on the same cycle as `start_i` is the first byte of a new message: it is folded into the all-ones preset, not into the old remainder.
- R9: On a ready cycle with `valid_i` and `start_i` both low, `crc_o` does not change. Gaps inside a message do not alter the result.
- R10: Bytes accepted without `start_i` continue the running remainder of the previous message.
- R11: Every one of the 256 byte values, sent alone after a preset, gives the checksum of the bitwise definition in R5. Every word of the lookup memory is therefore checked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; restarts the table build |
| start_i | input | 1 | Preset the remainder to all ones for a new message |
| valid_i | input | 1 | `data_i` holds a byte to fold in this cycle |
| data_i | input | 8 | Message byte |
| ready_o | output | 1 | Table built; bytes and presets are accepted |
| crc_o | output | 32 | Complement of the running remainder |

## Verification
A wrong word in the lookup memory stays hidden until a byte addresses that index. From then on every later checksum of the message is wrong. Sending each byte value alone after a preset exposes such a fault within one cycle of that byte. A fault in the build sequencer shows as `ready_o` rising on the wrong edge, which is visible the moment it happens. A bad pending/fold step in the pipelined update shows only when bytes arrive back to back or after a gap. For this reason, streams with and without gaps are compared against the bitwise model on every cycle.

// File: rtl/crc32_tbl_pkg.sv
package crc32_tbl_pkg;

  // Build sequencer phases
  typedef enum logic [0:0] {
    BLD_FILL = 1'b0,
    BLD_DONE = 1'b1
  } bld_state_e;

endpackage

// File: rtl/crc32_tbl_builder.sv
module crc32_tbl_builder #(
  parameter int          CRC_W = 32,
  parameter int          IDX_W = 8,
  parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
  input  logic             clk,
  input  logic             rst,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_addr,
  output logic [CRC_W-1:0] wr_data,
  output logic             done
);
  import crc32_tbl_pkg::*;

  localparam int STEP_W = (IDX_W > 1) ? $clog2(IDX_W) : 1;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(IDX_W - 1);

  bld_state_e         st;
  logic [IDX_W-1:0]   idx;
  logic [STEP_W-1:0]  step;
  logic [CRC_W-1:0]   work;
  logic [CRC_W-1:0]   work_in;
  logic [CRC_W-1:0]   work_nx;
  logic               last_step;

  always_comb begin
    // the first step of each index seeds the register with the index itself
    work_in   = (step == '0) ? {{(CRC_W-IDX_W){1'b0}}, idx} : work;
    work_nx   = work_in[0] ? ((work_in >> 1) ^ POLY) : (work_in >> 1);
    last_step = (step == LAST_STEP);
    wr_en     = (st == BLD_FILL) && last_step;
    wr_addr   = idx;
    wr_data   = work_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= BLD_FILL;
      idx  <= '0;
      step <= '0;
      work <= '0;
      done <= 1'b0;
    end else if (st == BLD_FILL) begin
      work <= work_nx;
      if (last_step) begin
        step <= '0;
        idx  <= idx + 1'b1;
        if (idx == '1) begin
          st   <= BLD_DONE;
          done <= 1'b1;
        end
      end else begin
        step <= step + 1'b1;
      end
    end
  end

endmodule

// File: rtl/crc32_tbl_ram.sv
module crc32_tbl_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // simple dual-port memory with a registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end

endmodule

// File: rtl/crc32_tbl_core.sv
module crc32_tbl_core #(
  parameter int          CRC_W = 32,
  parameter int          IDX_W = 8,
  parameter logic [CRC_W-1:0] INIT   = 32'hFFFFFFFF,
  parameter logic [CRC_W-1:0] XOROUT = 32'hFFFFFFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic [IDX_W-1:0] data_i,
  input  logic [CRC_W-1:0] tbl_q,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_addr,
  output logic [CRC_W-1:0] crc_o
);
  // acc holds the shifted remainder; when pend is set the table word
  // that belongs to the last byte still has to be XORed in
  logic [CRC_W-1:0] acc;
  logic             pend;
  logic [CRC_W-1:0] cur;
  logic [CRC_W-1:0] base;
  logic             take;

  always_comb begin
    cur     = pend ? (acc ^ tbl_q) : acc;
    base    = start_i ? INIT : cur;
    take    = en && valid_i;
    rd_en   = take;
    rd_addr = base[IDX_W-1:0] ^ data_i;
    crc_o   = cur ^ XOROUT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= INIT;
      pend <= 1'b0;
    end else if (en) begin
      if (take) begin
        acc  <= base >> IDX_W;
        pend <= 1'b1;
      end else begin
        acc  <= base;
        pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/crc32_table_engine.sv
module crc32_table_engine #(
  parameter int          CRC_W = 32,
  parameter int          IDX_W = 8,
  parameter logic [CRC_W-1:0] POLY   = 32'hEDB88320,
  parameter logic [CRC_W-1:0] INIT   = 32'hFFFFFFFF,
  parameter logic [CRC_W-1:0] XOROUT = 32'hFFFFFFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic [IDX_W-1:0] data_i,
  output logic             ready_o,
  output logic [CRC_W-1:0] crc_o
);
  logic             wr_en;
  logic [IDX_W-1:0] wr_addr;
  logic [CRC_W-1:0] wr_data;
  logic             rd_en;
  logic [IDX_W-1:0] rd_addr;
  logic [CRC_W-1:0] tbl_q;
  logic             done;

  crc32_tbl_builder #(.CRC_W(CRC_W), .IDX_W(IDX_W), .POLY(POLY)) u_builder (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .done    (done)
  );

  crc32_tbl_ram #(.AW(IDX_W), .DW(CRC_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (rd_en),
    .raddr (rd_addr),
    .q     (tbl_q)
  );

  crc32_tbl_core #(.CRC_W(CRC_W), .IDX_W(IDX_W), .INIT(INIT), .XOROUT(XOROUT)) u_core (
    .clk     (clk),
    .rst     (rst),
    .en      (done),
    .start_i (start_i),
    .valid_i (valid_i),
    .data_i  (data_i),
    .tbl_q   (tbl_q),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .crc_o   (crc_o)
  );

  assign ready_o = done;

endmodule

// File: rtl/crc32_tbl_checker.sv
module crc32_tbl_checker #(
  parameter int          CRC_W = 32,
  parameter int          IDX_W = 8,
  parameter logic [CRC_W-1:0] INIT   = 32'hFFFFFFFF,
  parameter logic [CRC_W-1:0] XOROUT = 32'hFFFFFFFF
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             valid_i,
  input logic             ready_o,
  input logic [CRC_W-1:0] crc_o
);
  localparam int BUILD = (1 << IDX_W) * IDX_W;
  localparam int CNT_W = $clog2(BUILD + 1) + 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (!ready_o && cnt < CNT_W'(BUILD)) cnt <= cnt + 1'b1;
  end

  a_r1_busy_during_build: assert property (@(posedge clk) disable iff (rst)
    (cnt < CNT_W'(BUILD)) |-> !ready_o);

  a_r2_build_length: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> (cnt == CNT_W'(BUILD)));

  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o);

  a_r4_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    !ready_o |=> $stable(crc_o));

  a_r7_preset: assert property (@(posedge clk) disable iff (rst)
    (ready_o && start_i && !valid_i) |=> (crc_o == (INIT ^ XOROUT)));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !start_i && !valid_i) |=> $stable(crc_o));

endmodule

bind crc32_table_engine crc32_tbl_checker #(
  .CRC_W(CRC_W), .IDX_W(IDX_W), .INIT(INIT), .XOROUT(XOROUT)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .valid_i (valid_i),
  .ready_o (ready_o),
  .crc_o   (crc_o)
);

// File: tb/crc32_table_engine_bench.sv
`timescale 1ns/1ps
module crc32_table_engine_bench;
  localparam logic [31:0] POLY  = 32'hEDB88320;
  localparam logic [31:0] INIT  = 32'hFFFFFFFF;
  localparam int          BUILD = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  data_i = 8'h00;
  logic        ready_o;
  logic [31:0] crc_o;

  int    nchk = 0;
  int    nerr = 0;
  int    ec = 0;
  logic  rdy_m = 1'b0;
  logic [31:0] m = INIT;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  crc32_table_engine u_crc32_table_engine (
    .clk(clk), .rst(rst), .start_i(start_i), .valid_i(valid_i),
    .data_i(data_i), .ready_o(ready_o), .crc_o(crc_o)
  );

  function automatic logic [31:0] fold(logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle, advance the model at the edge, compare after it
  task automatic cyc(input string req, input logic s, input logic v, input logic [7:0] d);
    start_i = s; valid_i = v; data_i = d;
    @(posedge clk);
    if (rdy_m) begin
      if (v) m = fold(s ? INIT : m, d);
      else if (s) m = INIT;
    end else begin
      ec++;
      if (ec == BUILD) rdy_m = 1'b1;
    end
    @(negedge clk);
    chk(rdy_m ? "R3 ready" : "R2 ready", {31'h0, ready_o}, {31'h0, rdy_m});
    chk(req, crc_o, ~m);
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R1 ready in reset", {31'h0, ready_o}, 32'h0);
      chk("R1 crc in reset", crc_o, 32'h0);
    end
    rst = 1'b0;

    // R4: inputs toggled during the build are ignored
    for (int i = 0; i < BUILD; i++)
      cyc("R4 busy hold", i[3], i[0], i[7:0]);
    chk("R2 ready after build", {31'h0, ready_o}, 32'h1);
    chk("R4 preset kept", crc_o, 32'h0);

    // R6/R8: check string, first byte carries start
    for (int i = 0; i < 9; i++)
      cyc("R8 start with byte", i == 0, 1'b1, 8'h31 + 8'(i));
    cyc("R9 idle", 1'b0, 1'b0, 8'h00);
    chk("R6 check value", crc_o, 32'hCBF43926);

    // R7: preset alone, then the string with gaps (R9)
    cyc("R7 preset", 1'b1, 1'b0, 8'h55);
    chk("R7 zero after preset", crc_o, 32'h0);
    for (int i = 0; i < 9; i++) begin
      cyc("R9 gap stream", 1'b0, 1'b1, 8'h31 + 8'(i));
      cyc("R9 gap", 1'b0, 1'b0, 8'hA5);
    end
    chk("R9 check value with gaps", crc_o, 32'hCBF43926);

    // R10: continue without preset
    for (int i = 0; i < 9; i++)
      cyc("R10 continue", 1'b0, 1'b1, 8'h31 + 8'(i));
    chk("R10 continued differs", {31'h0, crc_o == 32'hCBF43926}, 32'h0);

    // R11: every byte value alone, back to back with start each time
    for (int i = 0; i < 256; i++)
      cyc("R11 single byte", 1'b1, 1'b1, 8'(i));

    // R5: long back-to-back stream, then mixed traffic
    cyc("R7 preset", 1'b1, 1'b0, 8'h00);
    for (int i = 0; i < 300; i++) begin
      step_lfsr();
      cyc("R5 stream", 1'b0, 1'b1, lfsr[7:0]);
    end
    for (int i = 0; i < 300; i++) begin
      step_lfsr();
      cyc("R5 mixed", lfsr[15] & lfsr[14] & lfsr[13], lfsr[9] | lfsr[11], lfsr[7:0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule